// File: doc/BRIEF.md
# Z80 I/O Port Register Bank

The block watches a Z80 bus from a fast system clock and turns every I/O cycle into per-port events for the whole 8-bit port space. A write to a port raises that port's own bit in a 256-bit write strobe for one fast clock and leaves the written byte in that port's entry of a 256-entry register file, where it stays until the port is written again. A read from a port raises that port's bit in a 256-bit read strobe. If the port falls inside a parameterised readable window, the block also drives the matching byte from a 256-entry input array onto the Z80 data bus.

The bus pins are registered once in the fast domain. Rising edges of the Z80 clock are found from that registered copy and counted from the start of the I/O cycle. Write data is captured, and the read response is started, once a set number of Z80 clock rises have been counted. Interrupt acknowledge cycles are ignored. The arrays are passed as flat vectors, with port n occupying bits n*8+7 down to n*8.

Top module: `zio_port_bank`

## Requirements
- R1: The port number is address bits 7:0, and the upper address bits are ignored. An I/O cycle is one where iorq_n is low and m1_n is high.
- R2: A write to port n makes wr_strobe bit n high for exactly one fast clock, and no other bit of wr_strobe is high.
- R3: In a write to port n, the data-bus byte is stored in wr_data bits n*8+7:n*8. The value is visible in the same cycle as the strobe and is kept until port n is written again.
- R4: A read from port n makes rd_strobe bit n high for exactly one fast clock, for any n from 0 to 255.
- R5: bus_oe goes high on a read only when RD_LO <= n <= RD_HI. The defaults are 240 and 249, and both limits are inclusive.
- R6: While bus_oe is high, bus_dout equals rd_data bits n*8+7:n*8. bus_oe and bus_dout return to 0 within three fast clocks after iorq_n or rd_n goes high.
- R7: Write data is sampled, and the write strobe issued, after WR_POS rising Z80 clock edges of the cycle (default 2). The strobe comes before the next Z80 rise.
- R8: The read strobe and the bus drive begin after RD_POS rising Z80 clock edges of the cycle (default 2).
- R9: A cycle with iorq_n and m1_n both low (interrupt acknowledge) produces no strobe and never raises bus_oe.
- R10: Each I/O cycle produces at most one strobe, however long it lasts. The next strobe needs iorq_n to go high first.
- R11: After reset, all strobes are zero, bus_oe is low and every wr_data entry is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| arst_n | input | 1 | Asynchronous active-low reset |
| z_clk | input | 1 | Z80 clock as seen on the bus |
| z_addr | input | 16 | Z80 address bus |
| z_iorq_n | input | 1 | I/O request, active low |
| z_m1_n | input | 1 | Machine cycle one, active low |
| z_rd_n | input | 1 | Read, active low |
| z_wr_n | input | 1 | Write, active low |
| z_din | input | 8 | Data bus as driven by the CPU |
| rd_data | input | 2048 | Per-port read bytes, port n at n*8 |
| wr_strobe | output | 256 | One-hot write pulse per port |
| wr_data | output | 2048 | Last byte written per port, port n at n*8 |
| rd_strobe | output | 256 | One-hot read pulse per port |
| bus_dout | output | 8 | Byte to drive onto the Z80 data bus |
| bus_oe | output | 1 | Data bus drive enable |

## Verification
A Z80 clock rise on the pins reaches the strobe outputs three fast clocks later: one input register, one cycle-position counter and one strobe register. The bench holds each Z80 clock phase for four fast clocks, so a strobe must appear while the bench's own rise count for the cycle still equals the configured position. The monitor records that count with every strobe it pops. Write data changes from a decoy to the real byte only after the first rise, so a capture taken too early is caught. bus_oe and bus_dout are sampled in the low phase after the third rise and again three fast clocks after the cycle ends.

// File: rtl/zio_pkg.sv
package zio_pkg;
  parameter int unsigned PORT_W = 8;
  parameter int unsigned DATA_W = 8;
  parameter int unsigned ADDR_W = 16;

  typedef struct packed {
    logic [PORT_W-1:0] port;
    logic              iorq_n;
    logic              m1_n;
    logic              rd_n;
    logic              wr_n;
    logic [DATA_W-1:0] din;
    logic              zrise;
  } zio_bus_t;

  function automatic logic in_window(input logic [PORT_W-1:0] p,
                                     input int unsigned lo,
                                     input int unsigned hi);
    return (32'(p) >= lo) && (32'(p) <= hi);
  endfunction
endpackage

// File: rtl/zio_bus_sampler.sv
module zio_bus_sampler
  import zio_pkg::*;
(
  input  logic              clk,
  input  logic              arst_n,
  input  logic              z_clk,
  input  logic [ADDR_W-1:0] z_addr,
  input  logic              z_iorq_n,
  input  logic              z_m1_n,
  input  logic              z_rd_n,
  input  logic              z_wr_n,
  input  logic [DATA_W-1:0] z_din,
  output logic              rst_n_o,
  output zio_bus_t          bus_o
);
  logic rs_meta, rs_sync;
  logic zc_q, zc_q2;
  logic [PORT_W-1:0] port_q;
  logic iorq_q, m1_q, rd_q, wr_q;
  logic [DATA_W-1:0] din_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      rs_meta <= 1'b0;
      rs_sync <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_sync <= rs_meta;
    end
  end
  assign rst_n_o = rs_sync;

  always_ff @(posedge clk or negedge rs_sync) begin
    if (!rs_sync) begin
      zc_q   <= 1'b0;
      zc_q2  <= 1'b0;
      port_q <= '0;
      iorq_q <= 1'b1;
      m1_q   <= 1'b1;
      rd_q   <= 1'b1;
      wr_q   <= 1'b1;
      din_q  <= '0;
    end else begin
      zc_q   <= z_clk;
      zc_q2  <= zc_q;
      port_q <= z_addr[PORT_W-1:0];
      iorq_q <= z_iorq_n;
      m1_q   <= z_m1_n;
      rd_q   <= z_rd_n;
      wr_q   <= z_wr_n;
      din_q  <= z_din;
    end
  end

  always_comb begin
    bus_o.port   = port_q;
    bus_o.iorq_n = iorq_q;
    bus_o.m1_n   = m1_q;
    bus_o.rd_n   = rd_q;
    bus_o.wr_n   = wr_q;
    bus_o.din    = din_q;
    bus_o.zrise  = zc_q & ~zc_q2;
  end
endmodule

// File: rtl/zio_cycle_timer.sv
module zio_cycle_timer
  import zio_pkg::*;
#(
  parameter int unsigned WR_POS = 2,
  parameter int unsigned RD_POS = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  zio_bus_t bus_i,
  output logic     io_active,
  output logic     wr_fire,
  output logic     rd_fire
);
  localparam int unsigned CMAX = (WR_POS > RD_POS) ? WR_POS : RD_POS;
  localparam int unsigned CW   = $clog2(CMAX + 2);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;

  always_comb begin
    io_active = !bus_i.iorq_n && bus_i.m1_n;
    wr_fire   = io_active && !done_q && !bus_i.wr_n && (32'(cnt_q) >= WR_POS);
    rd_fire   = io_active && !done_q && !bus_i.rd_n && (32'(cnt_q) >= RD_POS);
  end

  always_comb begin
    cnt_d  = cnt_q;
    done_d = done_q;
    if (!io_active) begin
      cnt_d  = '0;
      done_d = 1'b0;
    end else begin
      if (bus_i.zrise && (32'(cnt_q) != CMAX)) cnt_d = cnt_q + 1'b1;
      if (wr_fire || rd_fire) done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end
endmodule

// File: rtl/zio_wr_bank.sv
module zio_wr_bank
  import zio_pkg::*;
#(
  parameter int unsigned NPORT = 1 << PORT_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_fire,
  input  logic [PORT_W-1:0]       port,
  input  logic [DATA_W-1:0]       din,
  output logic [NPORT-1:0]        wr_stb,
  output logic [NPORT*DATA_W-1:0] wr_data
);
  logic [NPORT-1:0] hit;

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    assign hit[g] = wr_fire && (32'(port) == g);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wr_stb[g] <= 1'b0;
        wr_data[g*DATA_W +: DATA_W] <= '0;
      end else begin
        wr_stb[g] <= hit[g];
        if (hit[g]) wr_data[g*DATA_W +: DATA_W] <= din;
      end
    end
  end
endmodule

// File: rtl/zio_rd_drive.sv
module zio_rd_drive
  import zio_pkg::*;
#(
  parameter int unsigned NPORT = 1 << PORT_W,
  parameter int unsigned RD_LO = 240,
  parameter int unsigned RD_HI = 249
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    rd_fire,
  input  logic                    rd_hold,
  input  logic [PORT_W-1:0]       port,
  input  logic [NPORT*DATA_W-1:0] rd_data,
  output logic [NPORT-1:0]        rd_stb,
  output logic [DATA_W-1:0]       bus_dout,
  output logic                    bus_oe
);
  logic [NPORT-1:0]  stb_d;
  logic              oe_d;
  logic [DATA_W-1:0] dout_d;
  logic              win;

  assign win = in_window(port, RD_LO, RD_HI);

  for (genvar g = 0; g < NPORT; g++) begin : g_dec
    assign stb_d[g] = rd_fire && (32'(port) == g);
  end

  always_comb begin
    oe_d   = bus_oe;
    dout_d = bus_dout;
    if (rd_fire) begin
      oe_d   = win;
      dout_d = win ? rd_data[32'(port)*DATA_W +: DATA_W] : '0;
    end else if (!rd_hold) begin
      oe_d   = 1'b0;
      dout_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_stb   <= '0;
      bus_oe   <= 1'b0;
      bus_dout <= '0;
    end else begin
      rd_stb   <= stb_d;
      bus_oe   <= oe_d;
      bus_dout <= dout_d;
    end
  end
endmodule

// File: rtl/zio_port_bank.sv
module zio_port_bank
  import zio_pkg::*;
#(
  parameter int unsigned WR_POS = 2,
  parameter int unsigned RD_POS = 2,
  parameter int unsigned RD_LO  = 240,
  parameter int unsigned RD_HI  = 249,
  localparam int unsigned NPORT = 1 << PORT_W
) (
  input  logic                    clk,
  input  logic                    arst_n,
  input  logic                    z_clk,
  input  logic [ADDR_W-1:0]       z_addr,
  input  logic                    z_iorq_n,
  input  logic                    z_m1_n,
  input  logic                    z_rd_n,
  input  logic                    z_wr_n,
  input  logic [DATA_W-1:0]       z_din,
  input  logic [NPORT*DATA_W-1:0] rd_data,
  output logic [NPORT-1:0]        wr_strobe,
  output logic [NPORT*DATA_W-1:0] wr_data,
  output logic [NPORT-1:0]        rd_strobe,
  output logic [DATA_W-1:0]       bus_dout,
  output logic                    bus_oe
);
  logic        rst_n_s;
  zio_bus_t    bus_q;
  logic        io_active, wr_fire, rd_fire, rd_hold;
  logic        q_iorq_n, q_m1_n, q_rd_n;
  logic [PORT_W-1:0] q_port;

  zio_bus_sampler u_smp (
    .clk(clk), .arst_n(arst_n), .z_clk(z_clk), .z_addr(z_addr),
    .z_iorq_n(z_iorq_n), .z_m1_n(z_m1_n), .z_rd_n(z_rd_n), .z_wr_n(z_wr_n),
    .z_din(z_din), .rst_n_o(rst_n_s), .bus_o(bus_q)
  );

  assign q_iorq_n = bus_q.iorq_n;
  assign q_m1_n   = bus_q.m1_n;
  assign q_rd_n   = bus_q.rd_n;
  assign q_port   = bus_q.port;

  zio_cycle_timer #(.WR_POS(WR_POS), .RD_POS(RD_POS)) u_tmr (
    .clk(clk), .rst_n(rst_n_s), .bus_i(bus_q),
    .io_active(io_active), .wr_fire(wr_fire), .rd_fire(rd_fire)
  );

  assign rd_hold = io_active && !bus_q.rd_n;

  zio_wr_bank #(.NPORT(NPORT)) u_wr (
    .clk(clk), .rst_n(rst_n_s), .wr_fire(wr_fire), .port(bus_q.port),
    .din(bus_q.din), .wr_stb(wr_strobe), .wr_data(wr_data)
  );

  zio_rd_drive #(.NPORT(NPORT), .RD_LO(RD_LO), .RD_HI(RD_HI)) u_rd (
    .clk(clk), .rst_n(rst_n_s), .rd_fire(rd_fire), .rd_hold(rd_hold),
    .port(bus_q.port), .rd_data(rd_data), .rd_stb(rd_strobe),
    .bus_dout(bus_dout), .bus_oe(bus_oe)
  );
endmodule

// File: rtl/zio_port_bank_chk.sv
module zio_port_bank_chk #(
  parameter int unsigned NPORT = 256,
  parameter int unsigned DW    = 8,
  parameter int unsigned RD_LO = 240,
  parameter int unsigned RD_HI = 249
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NPORT-1:0]    wr_strobe,
  input logic [NPORT-1:0]    rd_strobe,
  input logic [NPORT*DW-1:0] wr_data,
  input logic                bus_oe,
  input logic [DW-1:0]       bus_dout,
  input logic                q_iorq_n,
  input logic                q_m1_n,
  input logic                q_rd_n,
  input logic [7:0]          q_port
);
  a_r2_wr_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_strobe));
  a_r4_rd_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_strobe));
  a_r3_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(|wr_strobe) |-> $stable(wr_data));
  a_r5_oe_window: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> ((32'(q_port) >= RD_LO) && (32'(q_port) <= RD_HI)));
  a_r6_oe_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_oe) |-> (!q_iorq_n && !q_rd_n));
  a_r6_dout_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe |-> (bus_dout == '0));
  a_r9_ack_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!q_iorq_n && !q_m1_n && $past(!q_iorq_n && !q_m1_n)) |->
      (!(|wr_strobe) && !(|rd_strobe) && !$rose(bus_oe)));
  a_r10_single_wr: assert property (@(posedge clk) disable iff (!rst_n)
    (|wr_strobe) |=> !(|wr_strobe));
  a_r10_single_rd: assert property (@(posedge clk) disable iff (!rst_n)
    (|rd_strobe) |=> !(|rd_strobe));
endmodule

bind zio_port_bank zio_port_bank_chk #(
  .NPORT(NPORT), .DW(zio_pkg::DATA_W), .RD_LO(RD_LO), .RD_HI(RD_HI)
) u_chk (
  .clk(clk), .rst_n(rst_n_s), .wr_strobe(wr_strobe), .rd_strobe(rd_strobe),
  .wr_data(wr_data), .bus_oe(bus_oe), .bus_dout(bus_dout),
  .q_iorq_n(q_iorq_n), .q_m1_n(q_m1_n), .q_rd_n(q_rd_n), .q_port(q_port)
);

// File: tb/zio_port_bank_tb.sv
module zio_port_bank_tb;
  localparam int POS   = 2;
  localparam int LO    = 240;
  localparam int HI    = 249;
  localparam int NP    = 256;

  typedef struct packed {
    logic       is_rd;
    logic [7:0] port;
    logic [7:0] data;
  } exp_t;

  logic clk, arst_n, z_clk, z_iorq_n, z_m1_n, z_rd_n, z_wr_n;
  logic [15:0] z_addr;
  logic [7:0]  z_din;
  logic [NP*8-1:0] rd_data;
  logic [NP-1:0]   wr_strobe, rd_strobe;
  logic [NP*8-1:0] wr_data;
  logic [7:0]      bus_dout;
  logic            bus_oe;

  int   vectors = 0;
  int   errors  = 0;
  int   rise_cnt = 0;
  bit   mon_on = 0;
  exp_t exp_q[$];
  logic [7:0] wr_model [NP];

  zio_port_bank u_dut (
    .clk(clk), .arst_n(arst_n), .z_clk(z_clk), .z_addr(z_addr),
    .z_iorq_n(z_iorq_n), .z_m1_n(z_m1_n), .z_rd_n(z_rd_n), .z_wr_n(z_wr_n),
    .z_din(z_din), .rd_data(rd_data), .wr_strobe(wr_strobe), .wr_data(wr_data),
    .rd_strobe(rd_strobe), .bus_dout(bus_dout), .bus_oe(bus_oe)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [7:0] rd_val(input int p);
    return 8'(p) ^ 8'hA5;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  // Monitor: every strobe must match the head of the expected queue.
  always @(negedge clk) begin
    if (mon_on && ((|wr_strobe) || (|rd_strobe))) begin
      logic is_rd;
      int   p;
      exp_t e;
      is_rd = |rd_strobe;
      p = 0;
      for (int i = 0; i < NP; i++) if (wr_strobe[i] || rd_strobe[i]) p = i;
      check($countones({wr_strobe, rd_strobe}) == 1, "R2", "one-hot strobe",
            $countones({wr_strobe, rd_strobe}), 1);
      if (exp_q.size() == 0) begin
        check(0, "R10", "unexpected strobe (R9 ack / repeat) port", p, -1);
      end else begin
        e = exp_q.pop_front();
        check(e.is_rd == is_rd, is_rd ? "R4" : "R2", "strobe kind", is_rd, e.is_rd);
        check(e.port == 8'(p), "R1", "strobe port", p, e.port);
        check(rise_cnt == POS, is_rd ? "R8" : "R7", "Z80 rise position", rise_cnt, POS);
        if (!is_rd)
          check(wr_data[p*8 +: 8] == e.data, "R3", "stored write byte",
                wr_data[p*8 +: 8], e.data);
      end
    end
  end

  task automatic io_cycle(input bit is_rd, input bit ack, input logic [15:0] addr,
                          input logic [7:0] data);
    exp_t e;
    bit   win;
    @(negedge clk);
    z_addr = addr; z_iorq_n = 1'b0; z_m1_n = ~ack;
    z_rd_n = ~is_rd; z_wr_n = is_rd; z_din = ~data;
    win = is_rd && !ack && (int'(addr[7:0]) >= LO) && (int'(addr[7:0]) <= HI);
    if (!ack) begin
      e.is_rd = is_rd; e.port = addr[7:0];
      e.data  = is_rd ? rd_val(addr[7:0]) : data;
      exp_q.push_back(e);
      if (!is_rd) wr_model[addr[7:0]] = data;
    end
    rise_cnt = 0;
    repeat (4) @(negedge clk);
    for (int k = 1; k <= 4; k++) begin
      z_clk = 1'b1; rise_cnt = k;
      repeat (4) @(negedge clk);
      z_clk = 1'b0;
      if (k == 1) z_din = data;
      if (k == 3) begin
        check(bus_oe == win, ack ? "R9" : "R5", "bus_oe mid-cycle", bus_oe, win);
        if (win)
          check(bus_dout == rd_val(addr[7:0]), "R6", "bus_dout", bus_dout,
                rd_val(addr[7:0]));
      end
      repeat (4) @(negedge clk);
    end
    z_iorq_n = 1'b1; z_rd_n = 1'b1; z_wr_n = 1'b1; z_m1_n = 1'b1;
    repeat (3) @(negedge clk);
    check(bus_oe == 1'b0, "R6", "bus_oe released", bus_oe, 0);
    check(bus_dout == 8'h00, "R6", "bus_dout released", bus_dout, 0);
    check(exp_q.size() == 0, ack ? "R9" : "R10", "strobe missing, queue depth",
          exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "WDOG", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    for (int i = 0; i < NP; i++) begin
      rd_data[i*8 +: 8] = rd_val(i);
      wr_model[i] = 8'h00;
    end
    arst_n = 1'b0; z_clk = 1'b0; z_addr = '0; z_iorq_n = 1'b1; z_m1_n = 1'b1;
    z_rd_n = 1'b1; z_wr_n = 1'b1; z_din = '0;
    repeat (5) @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11: reset state
    check(wr_strobe == '0 && rd_strobe == '0, "R11", "strobes after reset",
          $countones({wr_strobe, rd_strobe}), 0);
    check(bus_oe == 1'b0, "R11", "bus_oe after reset", bus_oe, 0);
    check(wr_data == '0, "R11", "wr_data after reset", $countones(wr_data), 0);
    mon_on = 1;

    // Writes: R1 upper address ignored, R2/R3/R7
    io_cycle(0, 0, 16'h1234, 8'h5A);
    io_cycle(0, 0, 16'hFF00, 8'hC3);
    io_cycle(0, 0, 16'h00FF, 8'h81);
    io_cycle(0, 0, 16'hAB34, 8'h7E);   // R3 overwrite, R10 re-arm same port
    io_cycle(0, 0, 16'h00F3, 8'h11);
    // Reads: R4/R5/R6/R8 boundaries of the window
    io_cycle(1, 0, 16'h00EF, 8'h00);   // 239 outside
    io_cycle(1, 0, 16'h55F0, 8'h00);   // 240 inside
    io_cycle(1, 0, 16'h00F9, 8'h00);   // 249 inside
    io_cycle(1, 0, 16'h00FA, 8'h00);   // 250 outside
    io_cycle(1, 0, 16'h00F5, 8'h00);
    io_cycle(1, 0, 16'h0000, 8'h00);
    io_cycle(1, 0, 16'h00F5, 8'h00);   // R10 second read same port
    // R9: interrupt acknowledge cycles produce nothing
    io_cycle(1, 1, 16'h00F4, 8'h00);
    io_cycle(0, 1, 16'h0042, 8'h99);
    io_cycle(0, 0, 16'h0010, 8'h3C);

    // R3: retention sweep across the whole bank
    repeat (2) @(negedge clk);
    for (int i = 0; i < NP; i++)
      check(wr_data[i*8 +: 8] == wr_model[i], "R3", $sformatf("retained port %0d", i),
            wr_data[i*8 +: 8], wr_model[i]);
    finish_run();
  end
endmodule